// File: doc/BRIEF.md
# SDMA block transfer engine

This block moves a run of equal-sized data blocks between a card-side word stream and system memory using simple single-address DMA. Software sets up the starting system address, the block size, a boundary code, the block count and a transfer mode through a small register port. A write to the mode register with the DMA enable bit set starts the run. The engine then issues one 32-bit word request at a time on a request/acknowledge memory port. In the card-to-memory direction it takes words from the card input stream. In the memory-to-card direction it hands memory words to the card output stream.

When the next word address would land on a multiple of the programmed boundary size, the engine stops and raises a boundary status bit. It continues only after software writes the system address register again, and it continues from that new address. When the last word of the last block has moved, the engine sets a completion status bit. If the mode asks for an automatic stop command, it also gives a one-cycle stop pulse. Both status bits are cleared by writing 1 to them.

Top module: `sdma_engine`

## Requirements
- R1: After reset the status register (offset 0x10) reads 0, the system address register (offset 0x00) reads 0, and no memory request, card-input ready or card-output valid is asserted.
- R2: Host config register (offset 0x0C) bits [4:3] select the engine. Only 00 starts a transfer. With any other value, a start write causes no memory request and leaves the status at 0.
- R3: With mode bit 4 = 1 (card to memory), each accepted card-input word is written to memory. The words go to consecutive word addresses, starting at the system address.
- R4: With mode bit 4 = 0 (memory to card), memory words are read from consecutive word addresses starting at the system address. They appear on the card output in the same order.
- R5: Block config register (offset 0x04) holds the block size in bytes in bits [11:0] (a multiple of 4), the boundary code in [14:12] and the block count in [31:16]. With mode bit 1 (counter enable) and bit 5 (multi-block) both set, exactly size/4 × count words move. After the run, the system address register reads start + 4 × words.
- R6: With mode bit 5 clear, or with mode bit 1 clear, exactly one block moves, whatever the block count.
- R7: With mode bit 1 set and a block count of 0, a start sets completion in the same cycle and issues no memory request.
- R8: The boundary is 4096 << code bytes. When the address after a moved word is a multiple of the boundary and words remain, the engine pauses. Status bit 1 is set, status bit 2 (busy) stays 1, the address register reads the next address, and no further memory request is issued.
- R9: While paused, a write to the system address register resumes the run at the written address with the remaining words.
- R10: After the last word, status bit 0 (complete) is set and busy clears. If the last word ends exactly on a boundary, only completion is reported.
- R11: Writing 1 to status bit 0 or bit 1 clears it. Writing 0 leaves it unchanged.
- R12: With mode bit 2 set, a one-cycle auto-stop pulse follows the last word. With bit 2 clear, there is no pulse.
- R13: A memory request keeps its address and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| cin_valid | input | 1 | Card-input word valid |
| cin_data | input | 32 | Card-input word |
| cin_ready | output | 1 | Engine accepts a card-input word |
| cout_valid | output | 1 | Card-output word valid |
| cout_data | output | 32 | Card-output word |
| cout_ready | input | 1 | Card accepts the output word |
| auto_stop | output | 1 | One-cycle request for an automatic stop command |

## Verification
The assertions check, on every cycle:
- that a pending memory request holds its address and data until acknowledged;
- that a pause happens only on a boundary-aligned address, with no request outstanding;
- that completion appears only with the engine idle;
- that the two stream directions are never active together;
- that the auto-stop pulse lasts a single cycle.

Only the bench scenarios can show that the right number of words reach the right addresses with the right data, in both directions and across sizes and counts. The same holds for the single-block and zero-count rules, for resuming at a rewritten address, and for the clearing and selection behaviour seen through the register port.

// File: rtl/sdma_engine.sv
module sdma_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        cin_valid,
  input  logic [31:0] cin_data,
  output logic        cin_ready,
  output logic        cout_valid,
  output logic [31:0] cout_data,
  input  logic        cout_ready,
  output logic        auto_stop
);
  localparam logic [4:0] A_ADDR = 5'h00;
  localparam logic [4:0] A_BLK  = 5'h04;
  localparam logic [4:0] A_MODE = 5'h08;
  localparam logic [4:0] A_HOST = 5'h0C;
  localparam logic [4:0] A_STS  = 5'h10;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_PAUSE} state_t;
  state_t st;

  logic [31:0] sys_addr, hold;
  logic [11:0] blk_size;
  logic [2:0]  bnd_code;
  logic [15:0] blk_cnt, blocks_left;
  logic [9:0]  word_left;
  logic [5:0]  mode;
  logic [1:0]  dma_sel;
  logic        sts_done, sts_bnd, have;

  wire        idle      = (st == S_IDLE);
  wire        busy      = !idle;
  wire        paused    = (st == S_PAUSE);
  wire        dir_rd    = mode[4];
  wire [31:0] bmask     = (32'd4096 << bnd_code) - 32'd1;
  wire [9:0]  wpb       = (blk_size[11:2] == 10'd0) ? 10'd1 : blk_size[11:2];
  wire [31:0] next_addr = {sys_addr[31:2] + 30'd1, 2'b00};
  wire        last_word = (word_left == 10'd1);
  wire        last_all  = last_word && (blocks_left == 16'd1);

  assign mem_req    = (st == S_XFER) && (dir_rd ? have : !have);
  assign mem_we     = dir_rd;
  assign mem_addr   = {sys_addr[31:2], 2'b00};
  assign mem_wdata  = hold;
  assign cin_ready  = (st == S_XFER) && dir_rd && !have;
  assign cout_valid = (st == S_XFER) && !dir_rd && have;
  assign cout_data  = hold;

  wire adv = dir_rd ? (mem_req && mem_ack) : (cout_valid && cout_ready);

  always_comb begin
    case (reg_addr)
      A_ADDR:  reg_rdata = sys_addr;
      A_BLK:   reg_rdata = {blk_cnt, 1'b0, bnd_code, blk_size};
      A_MODE:  reg_rdata = {26'd0, mode};
      A_HOST:  reg_rdata = {27'd0, dma_sel, 3'd0};
      A_STS:   reg_rdata = {29'd0, busy, sts_bnd, sts_done};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sys_addr <= '0; hold <= '0; blk_size <= '0; bnd_code <= '0;
      blk_cnt <= '0; blocks_left <= '0; word_left <= '0; mode <= '0;
      dma_sel <= '0; sts_done <= 1'b0; sts_bnd <= 1'b0; have <= 1'b0;
      auto_stop <= 1'b0;
    end else begin
      auto_stop <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          A_ADDR: if (st != S_XFER) begin
            sys_addr <= reg_wdata;
            if (paused) st <= S_XFER;
          end
          A_BLK: if (idle) begin
            blk_size <= reg_wdata[11:0];
            bnd_code <= reg_wdata[14:12];
            blk_cnt  <= reg_wdata[31:16];
          end
          A_MODE: if (idle) begin
            mode <= reg_wdata[5:0];
            if (reg_wdata[0] && dma_sel == 2'b00) begin
              if (reg_wdata[1] && blk_cnt == 16'd0) sts_done <= 1'b1;
              else begin
                st          <= S_XFER;
                blocks_left <= (reg_wdata[1] && reg_wdata[5]) ? blk_cnt : 16'd1;
                word_left   <= wpb;
                have        <= 1'b0;
              end
            end
          end
          A_HOST: if (idle) dma_sel <= reg_wdata[4:3];
          A_STS: begin
            if (reg_wdata[0]) sts_done <= 1'b0;
            if (reg_wdata[1]) sts_bnd  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (st == S_XFER) begin
        if (cin_ready && cin_valid) begin
          hold <= cin_data;
          have <= 1'b1;
        end
        if (!dir_rd && mem_req && mem_ack) begin
          hold <= mem_rdata;
          have <= 1'b1;
        end
        if (adv) begin
          have     <= 1'b0;
          sys_addr <= next_addr;
          if (last_word) begin
            word_left   <= wpb;
            blocks_left <= blocks_left - 16'd1;
          end else begin
            word_left <= word_left - 10'd1;
          end
          if (last_all) begin
            st        <= S_IDLE;
            sts_done  <= 1'b1;
            auto_stop <= mode[2];
          end else if ((next_addr & bmask) == 32'd0) begin
            st      <= S_PAUSE;
            sts_bnd <= 1'b1;
          end
        end
      end
    end
  end

  a_r13_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
  a_r8_pause_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> (((sys_addr & bmask) == 32'd0) && sts_bnd));
  a_r8_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !mem_req);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_done) |-> !busy);
  a_r3_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(cin_ready && cout_valid));
  a_r12_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    auto_stop |=> !auto_stop);
endmodule

// File: tb/sdma_engine_tb.sv
module sdma_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = 5'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic cin_ready, cout_valid, auto_stop;
  logic [31:0] cin_data, cout_data;
  logic cout_ready;

  localparam logic [31:0] PAT = 32'hA5000000;

  int checks = 0, errors = 0;
  int nack = 0, seq = 0, nout = 0, nstop = 0, viol = 0;
  logic [31:0] mem [0:2047];
  logic [31:0] outbuf [0:255];
  logic [3:0] lat = 4'd0;
  logic prev_pend = 1'b0;
  logic [31:0] prev_addr = 32'd0, prev_wdata = 32'd0;

  always #4 clk = ~clk;

  sdma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cin_valid(1'b1),
    .cin_data(cin_data), .cin_ready(cin_ready), .cout_valid(cout_valid),
    .cout_data(cout_data), .cout_ready(cout_ready), .auto_stop(auto_stop));

  assign mem_rdata  = mem[mem_addr[12:2]];
  assign cin_data   = PAT + seq;
  assign cout_ready = lat[0] | lat[2];

  always @(posedge clk) begin
    lat <= lat + 4'd1;
    mem_ack <= mem_req && !mem_ack && (lat[1] | lat[3]);
    if (mem_req && mem_ack) begin
      nack <= nack + 1;
      if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
    end
    if (prev_pend && (!mem_req || mem_addr != prev_addr || (mem_we && mem_wdata != prev_wdata)))
      viol <= viol + 1;
    prev_pend  <= mem_req && !mem_ack;
    prev_addr  <= mem_addr;
    prev_wdata <= mem_wdata;
    if (cin_ready) seq <= seq + 1;
    if (cout_valid && cout_ready) begin
      outbuf[nout[7:0]] <= cout_data;
      nout <= nout + 1;
    end
    if (auto_stop) nstop <= nstop + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_flag(output logic [31:0] s);
    for (int i = 0; i < 4000; i++) begin
      rd(5'h10, s);
      if (s[1:0] != 2'b00) break;
    end
  endtask

  function automatic logic [31:0] mode_word(bit dir, bit cen, bit multi, bit astop);
    return {26'd0, multi, dir, 1'b0, astop, cen, 1'b1};
  endfunction

  task automatic run_plain(input bit dir, input int size, input int cnt, input bit cen,
                           input bit multi, input bit astop, input logic [31:0] base,
                           input string tag);
    logic [31:0] s, a;
    int n0, s0, o0, t0, words, bad;
    words = (cen && multi) ? (size / 4) * cnt : size / 4;
    n0 = nack; s0 = seq; o0 = nout; t0 = nstop;
    wr(5'h00, base);
    wr(5'h04, {cnt[15:0], 4'd7, size[11:0]});
    wr(5'h08, mode_word(dir, cen, multi, astop));
    wait_flag(s);
    repeat (3) @(negedge clk);
    chk(s[2:0] == 3'b001, {tag, " complete"}, s, 32'd1);
    chk(nack - n0 == words, {tag, " word count"}, nack - n0, words);
    rd(5'h00, a);
    chk(a == base + 4 * words, {tag, " end address"}, a, base + 4 * words);
    bad = 0;
    for (int k = 0; k < words; k++) begin
      if (dir) begin
        if (mem[base[12:2] + k] != PAT + s0 + k) bad++;
      end else begin
        if (outbuf[(o0 + k) % 256] != mem[base[12:2] + k]) bad++;
      end
    end
    chk(bad == 0, {tag, dir ? " R3 data" : " R4 data"}, bad, 0);
    chk(nstop - t0 == (astop ? 1 : 0), {tag, " R12 stop pulses"}, nstop - t0, astop ? 1 : 0);
    wr(5'h10, 32'd3);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s, a;
    int n0, s0, o0;
    for (int i = 0; i < 2048; i++) mem[i] = 32'h5A000000 + i * 7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(5'h10, s);
    chk(s == 32'd0, "R1 status after reset", s, 0);
    rd(5'h00, a);
    chk(a == 32'd0, "R1 address after reset", a, 0);
    chk(!mem_req && !cin_ready && !cout_valid, "R1 idle outputs", {mem_req, cin_ready, cout_valid}, 0);

    for (int d = 0; d < 2; d++)
      for (int si = 0; si < 3; si++)
        for (int c = 1; c <= 3; c++)
          run_plain(d[0], (si == 0) ? 4 : (si == 1) ? 12 : 32, c, 1'b1, 1'b1, c == 2,
                    d ? 32'h100 : 32'h800, "R5 sweep");

    run_plain(1'b1, 8, 3, 1'b1, 1'b0, 1'b0, 32'h100, "R6 single block");
    run_plain(1'b0, 8, 3, 1'b0, 1'b1, 1'b0, 32'h800, "R6 counter off");

    n0 = nack;
    wr(5'h00, 32'h100);
    wr(5'h04, {16'd0, 4'd7, 12'd16});
    wr(5'h08, mode_word(1'b1, 1'b1, 1'b1, 1'b0));
    rd(5'h10, s);
    chk(s == 32'd1, "R7 zero count completes", s, 1);
    repeat (20) @(negedge clk);
    chk(nack == n0, "R7 no requests", nack - n0, 0);
    wr(5'h10, 32'd0);
    rd(5'h10, s);
    chk(s == 32'd1, "R11 write 0 keeps bit", s, 1);
    wr(5'h10, 32'd1);
    rd(5'h10, s);
    chk(s == 32'd0, "R11 write 1 clears bit", s, 0);

    wr(5'h0C, 32'h10);
    wr(5'h04, {16'd1, 4'd7, 12'd16});
    wr(5'h08, mode_word(1'b1, 1'b1, 1'b1, 1'b0));
    repeat (30) @(negedge clk);
    rd(5'h10, s);
    chk(s == 32'd0 && nack == n0, "R2 non-zero select ignored", s, 0);
    wr(5'h0C, 32'h0);

    n0 = nack; s0 = seq;
    wr(5'h00, 32'hFF8);
    wr(5'h04, {16'd1, 4'd0, 12'd16});
    wr(5'h08, mode_word(1'b1, 1'b1, 1'b1, 1'b0));
    wait_flag(s);
    chk(s == 32'd6, "R8 paused status", s, 6);
    rd(5'h00, a);
    chk(a == 32'h1000, "R8 paused address", a, 32'h1000);
    repeat (20) @(negedge clk);
    chk(nack - n0 == 2, "R8 no requests while paused", nack - n0, 2);
    wr(5'h10, 32'd2);
    rd(5'h10, s);
    chk(s == 32'd4, "R11 clear boundary bit", s, 4);
    wr(5'h00, 32'h1800);
    wait_flag(s);
    repeat (3) @(negedge clk);
    chk(s == 32'd1, "R9 resumed run completes", s, 1);
    chk(nack - n0 == 4, "R9 total words", nack - n0, 4);
    chk(mem[32'hFF8 >> 2] == PAT + s0 && mem[32'hFFC >> 2] == PAT + s0 + 1,
        "R9 data before pause", mem[32'hFFC >> 2], PAT + s0 + 1);
    chk(mem[32'h1800 >> 2] == PAT + s0 + 2 && mem[32'h1804 >> 2] == PAT + s0 + 3,
        "R9 data at new address", mem[32'h1804 >> 2], PAT + s0 + 3);
    wr(5'h10, 32'd3);

    o0 = nout;
    wr(5'h00, 32'h1FF8);
    wr(5'h04, {16'd2, 4'd1, 12'd8});
    wr(5'h08, mode_word(1'b0, 1'b1, 1'b1, 1'b0));
    wait_flag(s);
    rd(5'h00, a);
    chk(s == 32'd6 && a == 32'h2000, "R8 code 1 pause", a, 32'h2000);
    wr(5'h10, 32'd2);
    wr(5'h00, 32'h1400);
    wait_flag(s);
    repeat (3) @(negedge clk);
    chk(s == 32'd1 && nout - o0 == 4, "R9 code 1 resume", nout - o0, 4);
    chk(outbuf[o0 % 256] == mem[32'h1FF8 >> 2] && outbuf[(o0 + 1) % 256] == mem[32'h1FFC >> 2] &&
        outbuf[(o0 + 2) % 256] == mem[32'h1400 >> 2] && outbuf[(o0 + 3) % 256] == mem[32'h1404 >> 2],
        "R4 order across pause", outbuf[(o0 + 2) % 256], mem[32'h1400 >> 2]);
    wr(5'h10, 32'd3);

    wr(5'h00, 32'hFF0);
    wr(5'h04, {16'd1, 4'd0, 12'd16});
    wr(5'h08, mode_word(1'b1, 1'b1, 1'b1, 1'b0));
    wait_flag(s);
    repeat (3) @(negedge clk);
    rd(5'h10, s);
    chk(s == 32'd1, "R10 last word on boundary", s, 1);
    wr(5'h10, 32'd3);

    chk(viol == 0, "R13 request held until ack", viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule